// File: doc/BRIEF.md
# Clock Output Gating and Test-Mode Controller

This block sits between a clock generator's internal frequency sources and its output pins. It receives one free-running waveform per output group (host, memory, fixed 66 MHz, PCI, interrupt-controller, 48 MHz and reference), together with one enable bit per output pin. It produces the gated per-pin clocks. Every gate opens and closes only while its source is low, so a pin never shows a shortened pulse. The same gating stops every output low when the active-low power-down input is asserted.

Two live select inputs and one strapped select bit pick the operating mode. One code tri-states all clock outputs. Another code puts the block in a test mode: every group is then derived from an externally supplied test clock by a fixed ratio, and all dividers start together. The remaining codes are decoded into host and memory rate codes for the synthesizers, and a register bit can raise the memory rate. The strapped bit shares a pad with the reference output. For a fixed number of cycles after reset the pad is read as an input. Its value is then latched and held, and the pad becomes the reference clock output.

All logic runs on one fast sampling clock `clk`. The group sources and the test clock come in as levels sampled by that clock.

Top module: `clk_out_ctl`

## Requirements
- R1: When `sel_lo` = 2'b00, `clk_oe` and `ref_pad_oe` are 0 from the following cycle on. Any other code drives `clk_oe` to 1.
- R2: When `sel_lo` = 2'b01, test mode applies whatever the strapped bit is. Host, memory and 48 MHz outputs run at `tst_clk`/2 with 50% duty. The 66 MHz outputs run at `tst_clk`/3 and are high for one test-clock period out of three. PCI and interrupt-controller outputs run at `tst_clk`/6 with 50% duty. The reference pad copies `tst_clk` undivided.
- R3: In the other codes, each enabled output reproduces the high and low times of its group source.
- R4: The rate code is `{strap, sel_lo}`: 010 gives `cpu_rate`=0 and `mem_rate`=0; 011 gives 1 and 0; 110 gives 2 and 1; 111 gives 2 and 0. Every other code gives 1 and 0. Rate encodings: `cpu_rate` 0 = 66.6 MHz, 1 = 100 MHz, 2 = 133.3 MHz; `mem_rate` 0 = 100 MHz, 1 = 133.3 MHz.
- R5: `mem_fast` = 1 forces `mem_rate` to 1 in every code.
- R6: While `pd_n` is 0, every clock output and the reference pad settle low within one source period and stay low. When `pd_n` returns to 1, they run again.
- R7: During the STRAP_CYC cycles after reset, `ref_pad_oe` is 0 and `ref_pad_in` is sampled. The last sample is latched, and later changes on `ref_pad_in` have no effect.
- R8: The latched strap bit reads 0 from reset until the sampling window ends.
- R9: An output whose enable bit is 0 stays low. With the enable bit at 1 it runs.
- R10: Enable and power-down changes act only while the source is low, so every output high pulse has the full source high time.
- R11: On entry to test mode all dividers restart from a common phase on a test-clock rising edge, so each PCI-group rising edge falls in the same cycle as a host-group and a 66 MHz-group rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high power-up reset |
| sel_lo | input | 2 | Live select bits |
| ref_pad_in | input | 1 | Strap value read from the shared pad |
| ref_pad_out | output | 1 | Reference clock driven onto the shared pad |
| ref_pad_oe | output | 1 | Pad drive enable (1 after strap latch, outside tri-state) |
| pd_n | input | 1 | Active-low power-down |
| tst_clk | input | 1 | Test clock level |
| grp_src | input | 7 | Group sources: 0 host, 1 memory, 2 fixed 66, 3 PCI, 4 interrupt ctrl, 5 48 MHz, 6 reference |
| out_en | input | 26 | Per-output enables, same index order as `clk_out` |
| mem_fast | input | 1 | Forces the memory rate code to 133.3 MHz |
| clk_out | output | 26 | Gated outputs: [2:0] host, [11:3] memory, [14:12] 66, [21:15] PCI, [23:22] interrupt ctrl, [24] USB, [25] dot |
| clk_oe | output | 1 | Output enable for all `clk_out` pins |
| cpu_rate | output | 2 | Host rate code |
| mem_rate | output | 1 | Memory rate code |

## Verification
The hardest situation to reach is an enable bit that changes while its source is high, since only that case could produce a runt pulse. The stimulus toggles one host enable at a cycle pattern that is coprime with the source period, so the toggles land on every phase, and it measures the length of every high run on that pin. Test-mode phase alignment is checked on every PCI rising edge, with the bench confirming that the host and 66 MHz pins rose in that same sample. Strap latching needs its own reset sequences so that both strap values reach the rate decoder.

// File: rtl/cko_pkg.sv
package cko_pkg;
  localparam int NGRP   = 7;
  localparam int GI_CPU = 0;
  localparam int GI_MEM = 1;
  localparam int GI_V66 = 2;
  localparam int GI_PCI = 3;
  localparam int GI_APC = 4;
  localparam int GI_U48 = 5;
  localparam int GI_REF = 6;

  localparam logic [1:0] CPU_R66  = 2'd0;
  localparam logic [1:0] CPU_R100 = 2'd1;
  localparam logic [1:0] CPU_R133 = 2'd2;
endpackage

// File: rtl/cko_strap.sv
module cko_strap #(
  parameter int STRAP_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_in,
  output logic strap,
  output logic done
);
  localparam int CW = $clog2(STRAP_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      done  <= 1'b0;
      strap <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(STRAP_CYC - 1)) begin
        done  <= 1'b1;
        strap <= pad_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(strap))); // R7

  AST_STRAP_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    !done |-> !strap); // R8
endmodule

// File: rtl/cko_testdiv.sv
module cko_testdiv (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tck,
  output logic d2,
  output logic d3,
  output logic d6
);
  logic       tprev;
  logic       started;
  logic [2:0] ph;
  logic       rise;

  assign rise = tck & ~tprev;

  always_ff @(posedge clk) begin
    if (rst) tprev <= 1'b0;
    else     tprev <= tck;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      started <= 1'b0;
      ph      <= 3'd0;
    end else if (rise) begin
      if (!started) started <= 1'b1;
      else          ph <= (ph == 3'd5) ? 3'd0 : ph + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      d2 <= 1'b0;
      d3 <= 1'b0;
      d6 <= 1'b0;
    end else begin
      d2 <= started & ~ph[0];
      d3 <= started & ((ph == 3'd0) || (ph == 3'd3));
      d6 <= started & (ph < 3'd3);
    end
  end

  AST_DIV_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(d6) |-> (d2 && d3)); // R11
endmodule

// File: rtl/cko_gate.sv
module cko_gate (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic en_req,
  output logic out
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= 1'b0;
    else if (!src) en_q <= en_req;
  end

  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else     out <= src & en_q;
  end

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(out) |-> !$past(src)); // R10

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (!en_req && !src) |=> ##1 !out); // R9
endmodule

// File: rtl/clk_out_ctl.sv
module clk_out_ctl
  import cko_pkg::*;
#(
  parameter int N_CPU     = 3,
  parameter int N_MEM     = 9,
  parameter int N_V66     = 3,
  parameter int N_PCI     = 7,
  parameter int N_APC     = 2,
  parameter int N_U48     = 2,
  parameter int STRAP_CYC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          sel_lo,
  input  logic                ref_pad_in,
  output logic                ref_pad_out,
  output logic                ref_pad_oe,
  input  logic                pd_n,
  input  logic                tst_clk,
  input  logic [6:0]          grp_src,
  input  logic [N_CPU+N_MEM+N_V66+N_PCI+N_APC+N_U48-1:0] out_en,
  input  logic                mem_fast,
  output logic [N_CPU+N_MEM+N_V66+N_PCI+N_APC+N_U48-1:0] clk_out,
  output logic                clk_oe,
  output logic [1:0]          cpu_rate,
  output logic                mem_rate
);
  localparam int O_MEM = N_CPU;
  localparam int O_V66 = O_MEM + N_MEM;
  localparam int O_PCI = O_V66 + N_V66;
  localparam int O_APC = O_PCI + N_PCI;
  localparam int O_U48 = O_APC + N_APC;
  localparam int NOUT  = O_U48 + N_U48;

  function automatic int grp_of(input int i);
    if (i < O_MEM) return GI_CPU;
    if (i < O_V66) return GI_MEM;
    if (i < O_PCI) return GI_V66;
    if (i < O_APC) return GI_PCI;
    if (i < O_U48) return GI_APC;
    return GI_U48;
  endfunction

  logic            test_q, pd_q, tck_q;
  logic [NGRP-1:0] src_q, gclk;
  logic            strap, strap_done;
  logic            d2, d3, d6;
  logic [1:0]      cpu_nx;
  logic            mem_nx;

  cko_strap #(.STRAP_CYC(STRAP_CYC)) u_strap (
    .clk(clk), .rst(rst), .pad_in(ref_pad_in), .strap(strap), .done(strap_done)
  );

  cko_testdiv u_div (
    .clk(clk), .rst(rst), .run(test_q), .tck(tck_q), .d2(d2), .d3(d3), .d6(d6)
  );

  always_comb begin
    case ({strap, sel_lo})
      3'b010:  begin cpu_nx = CPU_R66;  mem_nx = 1'b0; end
      3'b011:  begin cpu_nx = CPU_R100; mem_nx = 1'b0; end
      3'b110:  begin cpu_nx = CPU_R133; mem_nx = 1'b1; end
      3'b111:  begin cpu_nx = CPU_R133; mem_nx = 1'b0; end
      default: begin cpu_nx = CPU_R100; mem_nx = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_q   <= 1'b0;
      clk_oe   <= 1'b0;
      pd_q     <= 1'b0;
      tck_q    <= 1'b0;
      src_q    <= '0;
      cpu_rate <= CPU_R100;
      mem_rate <= 1'b0;
    end else begin
      test_q   <= (sel_lo == 2'b01);
      clk_oe   <= (sel_lo != 2'b00);
      pd_q     <= pd_n;
      tck_q    <= tst_clk;
      src_q    <= grp_src;
      cpu_rate <= cpu_nx;
      mem_rate <= mem_nx | mem_fast;
    end
  end

  always_comb begin
    if (test_q) begin
      gclk[GI_CPU] = d2;
      gclk[GI_MEM] = d2;
      gclk[GI_V66] = d3;
      gclk[GI_PCI] = d6;
      gclk[GI_APC] = d6;
      gclk[GI_U48] = d2;
      gclk[GI_REF] = tck_q;
    end else begin
      gclk = src_q;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int G = grp_of(i);
    cko_gate u_gate (
      .clk(clk), .rst(rst), .src(gclk[G]), .en_req(out_en[i] & pd_q), .out(clk_out[i])
    );
  end

  cko_gate u_ref_gate (
    .clk(clk), .rst(rst), .src(gclk[GI_REF]), .en_req(pd_q & strap_done), .out(ref_pad_out)
  );

  assign ref_pad_oe = strap_done & clk_oe;

  AST_TRI_OFF: assert property (@(posedge clk) disable iff (rst)
    (sel_lo == 2'b00) |=> (!clk_oe && !ref_pad_oe)); // R1

  AST_FAST_MEM: assert property (@(posedge clk) disable iff (rst)
    mem_fast |=> mem_rate); // R5
endmodule

// File: tb/test_clk_out_ctl.sv
module test_clk_out_ctl;
  localparam int NOUT = 26;
  localparam int REFK = 26;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      sel_lo = 2'b11;
  logic            ref_pad_in = 1'b1;
  logic            ref_pad_out, ref_pad_oe;
  logic            pd_n = 1'b1;
  logic            tst_clk;
  logic [6:0]      grp_src;
  logic [NOUT-1:0] out_en = '1;
  logic            mem_fast = 1'b0;
  logic [NOUT-1:0] clk_out;
  logic            clk_oe;
  logic [1:0]      cpu_rate;
  logic            mem_rate;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign grp_src[0] = (cyc % 6)  < 3;
  assign grp_src[1] = (cyc % 4)  < 2;
  assign grp_src[2] = (cyc % 8)  < 4;
  assign grp_src[3] = (cyc % 16) < 8;
  assign grp_src[4] = (cyc % 16) < 8;
  assign grp_src[5] = (cyc % 10) < 5;
  assign grp_src[6] = (cyc % 14) < 7;
  assign tst_clk    = (cyc % 4)  < 2;

  clk_out_ctl i_clk_out_ctl (
    .clk(clk), .rst(rst), .sel_lo(sel_lo), .ref_pad_in(ref_pad_in),
    .ref_pad_out(ref_pad_out), .ref_pad_oe(ref_pad_oe), .pd_n(pd_n),
    .tst_clk(tst_clk), .grp_src(grp_src), .out_en(out_en), .mem_fast(mem_fast),
    .clk_out(clk_out), .clk_oe(clk_oe), .cpu_rate(cpu_rate), .mem_rate(mem_rate)
  );

  function automatic logic sig(input int k);
    return (k == REFK) ? ref_pad_out : clk_out[k];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int k, input int exp_hi, input int exp_per, input string tag);
    int hi = 0;
    int per = 0;
    logic prev;
    int guard = 0;
    @(negedge clk);
    prev = sig(k);
    while (guard < 300) begin
      @(negedge clk);
      guard++;
      if (!prev && sig(k)) break;
      prev = sig(k);
    end
    hi = 1;
    while (guard < 600) begin
      @(negedge clk); guard++;
      if (sig(k)) hi++; else break;
    end
    per = hi + 1;
    while (guard < 900) begin
      @(negedge clk); guard++;
      if (!sig(k)) per++; else break;
    end
    check(hi == exp_hi, {tag, " high time"}, hi, exp_hi);
    check(per == exp_per, {tag, " period"}, per, exp_per);
  endtask

  task automatic do_reset(input logic pad);
    rst = 1'b1;
    ref_pad_in = pad;
    repeat (4) @(negedge clk);
    check(clk_out == '0, "reset clk_out low", int'(clk_out != '0), 0);
    check(ref_pad_oe == 1'b0, "R7 pad oe low in reset", ref_pad_oe, 0);
    rst = 1'b0;
  endtask

  task automatic t_strap;
    sel_lo = 2'b11;
    do_reset(1'b1);
    repeat (3) @(negedge clk);
    check(cpu_rate == 2'd1, "R8 strap reads 0 before latch", cpu_rate, 1);
    check(ref_pad_oe == 1'b0, "R7 pad oe low in window", ref_pad_oe, 0);
    repeat (12) @(negedge clk);
    check(cpu_rate == 2'd2, "R7 strap 1 latched", cpu_rate, 2);
    check(ref_pad_oe == 1'b1, "R7 pad oe after latch", ref_pad_oe, 1);
    ref_pad_in = 1'b0;
    repeat (20) @(negedge clk);
    check(cpu_rate == 2'd2, "R7 pad change ignored", cpu_rate, 2);
  endtask

  task automatic rate_case(input logic [1:0] s, input logic mf, input int ecpu, input int emem, input string tag);
    sel_lo = s;
    mem_fast = mf;
    repeat (3) @(negedge clk);
    check(int'(cpu_rate) == ecpu, {tag, " cpu_rate"}, cpu_rate, ecpu);
    check(int'(mem_rate) == emem, {tag, " mem_rate"}, mem_rate, emem);
  endtask

  task automatic t_rates_strap1;
    rate_case(2'b10, 1'b0, 2, 1, "R4 code 110");
    rate_case(2'b11, 1'b0, 2, 0, "R4 code 111");
    rate_case(2'b11, 1'b1, 2, 1, "R5 force on 111");
    mem_fast = 1'b0;
    sel_lo = 2'b11;
  endtask

  task automatic t_rates_strap0;
    rate_case(2'b10, 1'b0, 0, 0, "R4 code 010");
    rate_case(2'b11, 1'b0, 1, 0, "R4 code 011");
    rate_case(2'b10, 1'b1, 0, 1, "R5 force on 010");
    mem_fast = 1'b0;
    sel_lo = 2'b11;
  endtask

  task automatic t_run;
    sel_lo = 2'b11;
    repeat (4) @(negedge clk);
    check(clk_oe == 1'b1, "R1 oe in run code", clk_oe, 1);
    measure(0,  3, 6,  "R3 host");
    measure(3,  2, 4,  "R3 memory");
    measure(12, 4, 8,  "R3 fixed66");
    measure(15, 8, 16, "R3 pci");
    measure(22, 8, 16, "R3 intctl");
    measure(24, 5, 10, "R3 usb");
    measure(REFK, 7, 14, "R3 ref");
  endtask

  task automatic t_tristate;
    sel_lo = 2'b00;
    repeat (3) @(negedge clk);
    check(clk_oe == 1'b0, "R1 tri-state clk_oe", clk_oe, 0);
    check(ref_pad_oe == 1'b0, "R1 tri-state pad oe", ref_pad_oe, 0);
    sel_lo = 2'b11;
    repeat (3) @(negedge clk);
    check(clk_oe == 1'b1, "R1 oe restored", clk_oe, 1);
  endtask

  task automatic t_test;
    int aligned = 0;
    int rises = 0;
    logic pp, pc, pv;
    sel_lo = 2'b01;
    repeat (4) @(negedge clk);
    measure(0,  4, 8,  "R2 host /2");
    measure(3,  4, 8,  "R2 memory /2");
    measure(12, 4, 12, "R2 fixed66 /3");
    measure(15, 12, 24, "R2 pci /6");
    measure(22, 12, 24, "R2 intctl /6");
    measure(25, 4, 8,  "R2 dot /2");
    measure(REFK, 2, 4, "R2 ref undivided");
    @(negedge clk);
    pp = clk_out[15]; pc = clk_out[0]; pv = clk_out[12];
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (!pp && clk_out[15]) begin
        rises++;
        if (!pc && clk_out[0] && !pv && clk_out[12]) aligned++;
      end
      pp = clk_out[15]; pc = clk_out[0]; pv = clk_out[12];
    end
    check(rises >= 3, "R11 pci rises seen", rises, 3);
    check(aligned == rises, "R11 groups rise together", aligned, rises);
    sel_lo = 2'b11;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_enable;
    int h0 = 0;
    int h1 = 0;
    int run = 0;
    int bad = 0;
    int pulses = 0;
    logic prev;
    out_en[0] = 1'b0;
    repeat (12) @(negedge clk);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      h0 += int'(clk_out[0]);
      h1 += int'(clk_out[1]);
    end
    check(h0 == 0, "R9 disabled output stays low", h0, 0);
    check(h1 == 12, "R9 enabled neighbour runs", h1, 12);
    prev = clk_out[0];
    for (int c = 0; c < 210; c++) begin
      @(negedge clk);
      if (clk_out[0]) run++;
      else if (prev) begin
        pulses++;
        if (run != 3) bad++;
        run = 0;
      end
      prev = clk_out[0];
      if (c % 7 == 3) out_en[0] = ~out_en[0];
    end
    check(bad == 0, "R10 no shortened pulse", bad, 0);
    check(pulses > 5, "R10 pulses while toggling", pulses, 6);
    out_en[0] = 1'b1;
  endtask

  task automatic t_powerdown;
    int hi = 0;
    int run = 0;
    int bad = 0;
    logic prev;
    prev = clk_out[0];
    pd_n = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (clk_out[0]) run++;
      else if (prev) begin
        if (run != 3) bad++;
        run = 0;
      end
      prev = clk_out[0];
    end
    check(bad == 0, "R10 full pulse entering power-down", bad, 0);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (clk_out != '0 || ref_pad_out) hi++;
    end
    check(hi == 0, "R6 all outputs low in power-down", hi, 0);
    pd_n = 1'b1;
    measure(0, 3, 6, "R6 host resumes");
    measure(REFK, 7, 14, "R6 ref resumes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_strap();
    t_rates_strap1();
    t_run();
    t_tristate();
    t_test();
    t_enable();
    t_powerdown();
    sel_lo = 2'b11;
    do_reset(1'b0);
    repeat (12) @(negedge clk);
    t_rates_strap0();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule